// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host-write path of a byte-wide flash array and watches every accepted write cycle (address plus data). It recognises the multi-write unlock sequences that guard destructive and mode-changing operations. When a sequence completes, it raises exactly one single-cycle start pulse for one of six operations: byte program, sector erase, chip erase, boot-region lock, identification-mode entry or identification-mode exit.

Bus timing is reduced to a synchronous write-valid strobe that carries an address and data already latched. A busy input from the array controller freezes the decoder while an operation is running. The address and data of the write that completed a program or sector-erase sequence are held on `cmd_addr` and `cmd_data` for the controller to use. The `id_mode` flag tells the read path to return identification codes.

Only the low 12 address bits are compared. The second unlock address matches with bit 11 ignored, which is chosen by a parameter.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and after any reset that arrives part-way through a sequence, all pulses and `id_mode` are 0 and no partial sequence remains. The next write must begin a fresh unlock.
- R2: The sequence AA@555, 55@AAA, A0@555 followed by any write (data F0 included) raises `pgm_start` one cycle after that fourth write. In the same cycle, `cmd_addr` and `cmd_data` equal the fourth write's address and data.
- R3: Address bits above bit 11 are ignored in every comparison.
- R4: The second unlock write matches at low address AAA or at 2AA (bit 11 is a don't-care).
- R5: Unlock, 80@555, unlock, then 10@555 raises `chip_erase_start`.
- R6: Unlock, 80@555, unlock, then 30 at any address raises `sec_erase_start` one cycle after the sixth write, with `cmd_addr` equal to that write's address.
- R7: Unlock, 80@555, unlock, then 40@555 raises `lock_start`.
- R8: Unlock then 90@555 raises `id_enter`, and `id_mode` reads 1 from the same cycle.
- R9: `id_exit` is raised, and `id_mode` cleared, by unlock followed by F0@555, or by a single F0 write at any address outside the program-data step.
- R10: A write that does not match the expected address and data returns the decoder to idle without raising any pulse.
- R11: Writes made while `busy` is 1 raise no pulse and do not advance or reset the sequence.
- R12: At most one start pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One host write is presented this cycle |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | 8 | Latched write data |
| busy | input | 1 | Array operation in progress; writes are ignored |
| pgm_start | output | 1 | Byte-program start pulse |
| sec_erase_start | output | 1 | Sector-erase start pulse |
| chip_erase_start | output | 1 | Chip-erase start pulse |
| lock_start | output | 1 | Boot-region lock start pulse |
| id_enter | output | 1 | Identification-mode entry pulse |
| id_exit | output | 1 | Identification-mode exit pulse |
| cmd_addr | output | ADDR_W | Address of the write that completed a sequence |
| cmd_data | output | 8 | Data of the write that completed a sequence |
| id_mode | output | 1 | Identification mode active |

## Verification
Every complete sequence is driven once. Some are driven with upper address bits set and with the 2AA alias, which shows that only the low 12 bits and the alias masking decide a match. Broken sequences are also driven: a wrong unlock address, a wrong final data byte in the erase group, and a stray command byte from idle. These show that a mismatch returns to idle rather than waiting at a later step. Busy writes are placed at the start of a sequence, in the middle of one, and as a would-be F0 exit, to show that they neither advance nor reset the state. A reset in the middle of a sequence shows that the partial prefix is discarded.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam int CMP_W = 12;

   localparam logic [CMP_W-1:0] LADR_A     = 12'h555;
   localparam logic [CMP_W-1:0] LADR_B     = 12'hAAA;
   localparam logic [CMP_W-1:0] LADR_AMASK = 12'h7FF;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
   localparam logic [7:0] OP_PROG    = 8'hA0;
   localparam logic [7:0] OP_EGROUP  = 8'h80;
   localparam logic [7:0] OP_IDIN    = 8'h90;
   localparam logic [7:0] OP_IDOUT   = 8'hF0;
   localparam logic [7:0] OP_CHIP    = 8'h10;
   localparam logic [7:0] OP_SECT    = 8'h30;
   localparam logic [7:0] OP_LOCK    = 8'h40;

   typedef enum logic [2:0] {
      S_IDLE, S_KEY1, S_KEY2, S_PDATA, S_GRP3, S_GRP4, S_GRP5
   } seq_state_t;

   typedef enum logic [2:0] {
      C_NONE, C_PROG, C_SECT, C_CHIP, C_LOCK, C_IDIN, C_IDOUT
   } seq_cmd_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
   import flash_cmd_pkg::*;
#(
   parameter bit ALIAS_EN = 1'b1
) (
   input  logic [CMP_W-1:0] low_addr,
   output logic             hit_a,
   output logic             hit_b
);

   assign hit_a = (low_addr == LADR_A);

   generate
      if (ALIAS_EN) begin : g_alias
         assign hit_b = ((low_addr & LADR_AMASK) == (LADR_B & LADR_AMASK));
      end else begin : g_exact
         assign hit_b = (low_addr == LADR_B);
      end
   endgenerate

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import flash_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic       hit_a,
   input  logic       hit_b,
   input  logic [7:0] data,
   output seq_cmd_t   cmd
);

   seq_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      cmd  = C_NONE;
      if (accept) begin
         st_d = S_IDLE;
         if (st_q != S_PDATA && data == OP_IDOUT) begin
            cmd = C_IDOUT;
         end else begin
            unique case (st_q)
               S_IDLE:  if (hit_a && data == KEY_FIRST)  st_d = S_KEY1;
               S_KEY1:  if (hit_b && data == KEY_SECOND) st_d = S_KEY2;
               S_KEY2: begin
                  if (hit_a) begin
                     if (data == OP_PROG)        st_d = S_PDATA;
                     else if (data == OP_EGROUP) st_d = S_GRP3;
                     else if (data == OP_IDIN)   cmd  = C_IDIN;
                  end
               end
               S_PDATA: cmd = C_PROG;
               S_GRP3:  if (hit_a && data == KEY_FIRST)  st_d = S_GRP4;
               S_GRP4:  if (hit_b && data == KEY_SECOND) st_d = S_GRP5;
               S_GRP5: begin
                  if (data == OP_SECT)                cmd = C_SECT;
                  else if (hit_a && data == OP_CHIP)  cmd = C_CHIP;
                  else if (hit_a && data == OP_LOCK)  cmd = C_LOCK;
               end
               default: st_d = S_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= S_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter bit ALIAS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              busy,
   output logic              pgm_start,
   output logic              sec_erase_start,
   output logic              chip_erase_start,
   output logic              lock_start,
   output logic              id_enter,
   output logic              id_exit,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [7:0]        cmd_data,
   output logic              id_mode
);

   initial begin
      if (ADDR_W < CMP_W) $error("flash_cmd_seq: ADDR_W must be at least %0d", CMP_W);
   end

   logic     accept, hit_a, hit_b;
   seq_cmd_t cmd;

   assign accept = wr_valid && !busy;

   flash_cmd_match #(.ALIAS_EN(ALIAS_EN)) u_match (
      .low_addr (wr_addr[CMP_W-1:0]),
      .hit_a    (hit_a),
      .hit_b    (hit_b)
   );

   flash_cmd_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .hit_a  (hit_a),
      .hit_b  (hit_b),
      .data   (wr_data),
      .cmd    (cmd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pgm_start        <= 1'b0;
         sec_erase_start  <= 1'b0;
         chip_erase_start <= 1'b0;
         lock_start       <= 1'b0;
         id_enter         <= 1'b0;
         id_exit          <= 1'b0;
         id_mode          <= 1'b0;
         cmd_addr         <= '0;
         cmd_data         <= '0;
      end else begin
         pgm_start        <= (cmd == C_PROG);
         sec_erase_start  <= (cmd == C_SECT);
         chip_erase_start <= (cmd == C_CHIP);
         lock_start       <= (cmd == C_LOCK);
         id_enter         <= (cmd == C_IDIN);
         id_exit          <= (cmd == C_IDOUT);
         if (cmd == C_IDIN)       id_mode <= 1'b1;
         else if (cmd == C_IDOUT) id_mode <= 1'b0;
         if (cmd != C_NONE) begin
            cmd_addr <= wr_addr;
            cmd_data <= wr_data;
         end
      end
   end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
   parameter int ADDR_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              busy,
   input logic              pgm_start,
   input logic              sec_erase_start,
   input logic              chip_erase_start,
   input logic              lock_start,
   input logic              id_enter,
   input logic              id_exit,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [7:0]        cmd_data,
   input logic              id_mode
);

   logic [5:0] pulses;
   assign pulses = {pgm_start, sec_erase_start, chip_erase_start, lock_start, id_enter, id_exit};

   // R12
   one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pulses));

   // R11
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (pulses == 6'b0));

   // R2
   prog_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_start |-> ($past(wr_valid) && !$past(busy) && cmd_data == $past(wr_data)
                     && cmd_addr == $past(wr_addr)));

   // R6
   sect_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_erase_start |-> (cmd_addr == $past(wr_addr)));

   // R8
   id_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mode) |-> id_enter);

   // R9
   id_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_exit |-> !id_mode);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 19;
   localparam int NV = 54;

   // vector: {addr[18:0], data[7:0], busy, expected code[2:0], expected id_mode}
   // code: 0 none, 1 program, 2 sector erase, 3 chip erase, 4 lock, 5 id entry, 6 id exit
   localparam logic [31:0] VEC [NV] = '{
      // R2 program
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'hA0, 1'b0, 3'd0, 1'b0},
      {19'h12345, 8'h3C, 1'b0, 3'd1, 1'b0},
      // R3 upper bits set, R4 alias 2AA, F0 taken as program data
      {19'h7F555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h3A2AA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h55555, 8'hA0, 1'b0, 3'd0, 1'b0},
      {19'h40001, 8'hF0, 1'b0, 3'd1, 1'b0},
      // R5 chip erase
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'h80, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h002AA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'h10, 1'b0, 3'd3, 1'b0},
      // R6 sector erase
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'h80, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h23456, 8'h30, 1'b0, 3'd2, 1'b0},
      // R7 lock
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'h80, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'h40, 1'b0, 3'd4, 1'b0},
      // R8 id entry
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'h90, 1'b0, 3'd5, 1'b1},
      // R11 busy writes ignored, including F0
      {19'h00555, 8'hAA, 1'b1, 3'd0, 1'b1},
      {19'h00000, 8'hF0, 1'b1, 3'd0, 1'b1},
      // R9 single-write exit
      {19'h01234, 8'hF0, 1'b0, 3'd6, 1'b0},
      // R8 enter again, R9 three-write exit
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'h90, 1'b0, 3'd5, 1'b1},
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b1},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b1},
      {19'h00555, 8'hF0, 1'b0, 3'd6, 1'b0},
      // R10 bad second address, then stray writes
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00556, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'hA0, 1'b0, 3'd0, 1'b0},
      {19'h00000, 8'h12, 1'b0, 3'd0, 1'b0},
      // R10 wrong final byte in erase group
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'h80, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'h20, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'h10, 1'b0, 3'd0, 1'b0},
      // R11 busy write in mid sequence holds the state
      {19'h00555, 8'hAA, 1'b0, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b1, 3'd0, 1'b0},
      {19'h00AAA, 8'h55, 1'b0, 3'd0, 1'b0},
      {19'h00555, 8'hA0, 1'b0, 3'd0, 1'b0},
      {19'h00100, 8'h77, 1'b0, 3'd1, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          busy = 1'b0;
   logic          pgm_start, sec_erase_start, chip_erase_start, lock_start, id_enter, id_exit;
   logic [AW-1:0] cmd_addr;
   logic [7:0]    cmd_data;
   logic          id_mode;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_seq #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .pgm_start(pgm_start),
      .sec_erase_start(sec_erase_start), .chip_erase_start(chip_erase_start),
      .lock_start(lock_start), .id_enter(id_enter), .id_exit(id_exit),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .id_mode(id_mode)
   );

   function automatic logic [5:0] pulse_vec();
      return {pgm_start, sec_erase_start, chip_erase_start, lock_start, id_enter, id_exit};
   endfunction

   function automatic logic [5:0] code_mask(input logic [2:0] code);
      return (code == 3'd0) ? 6'b0 : (6'b100000 >> (code - 3'd1));
   endfunction

   function automatic string req_of(input logic [2:0] code);
      case (code)
         3'd1: return "R2";
         3'd2: return "R6";
         3'd3: return "R5";
         3'd4: return "R7";
         3'd5: return "R8";
         3'd6: return "R9";
         default: return "R10/R11";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one write cycle; outputs sampled at the following falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic b);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = b;
      @(negedge clk);
      wr_valid = 1'b0; busy = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1", {25'b0, pulse_vec(), id_mode}, 32'b0);

      for (int i = 0; i < NV; i++) begin
         logic [AW-1:0] va;
         logic [7:0]    vd;
         logic [2:0]    vc;
         va = VEC[i][31:13];
         vd = VEC[i][12:5];
         vc = VEC[i][3:1];
         wr(va, vd, VEC[i][4]);
         check(req_of(vc), {26'b0, pulse_vec()}, {26'b0, code_mask(vc)});
         check("R8/R9 id_mode", {31'b0, id_mode}, {31'b0, VEC[i][0]});
         if (vc == 3'd1) begin
            check("R2 addr", {13'b0, cmd_addr}, {13'b0, va});
            check("R2 data", {24'b0, cmd_data}, {24'b0, vd});
         end
         if (vc == 3'd2) check("R6 addr", {13'b0, cmd_addr}, {13'b0, va});
      end

      // R1 reset in mid sequence with id mode active
      wr(19'h00555, 8'hAA, 1'b0);
      wr(19'h00AAA, 8'h55, 1'b0);
      wr(19'h00555, 8'h90, 1'b0);
      check("R8", {31'b0, id_mode}, 32'd1);
      wr(19'h00555, 8'hAA, 1'b0);
      wr(19'h00AAA, 8'h55, 1'b0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R1", {25'b0, pulse_vec(), id_mode}, 32'b0);
      wr(19'h00555, 8'hA0, 1'b0);
      wr(19'h00040, 8'h11, 1'b0);
      check("R1", {26'b0, pulse_vec()}, 32'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule